// File: doc/BRIEF.md
# Receive Gain Hold for a Half-Duplex Line Modem

This block sets the receive amplifier gain of a half-duplex modem whose receiver stays active while the modem transmits, so the receiver also hears the modem's own output. In normal reception, a simple automatic gain loop watches 8-bit sample magnitudes from the converter. It steps a 3-bit gain code up or down once per observation window, so that the converter's full range is used without clipping.

While the active-low transmit data input is low, the block keeps the gain code that was in effect and drives the lowest gain instead. This stops the strong local transmit signal from pulling the loop away. When the transmit line returns high, the kept code is put back at once, with no re-acquisition. A power-down input returns the block to maximum gain and discards any kept value.

The gain code is 0 to 6 in 6 dB steps: code k means (6k - 6) dB, so 0 is -6 dB and 6 is +30 dB. The analog amplifier and the converter are outside the block.

Top module: `agc_gain_hold`

## Requirements
- R1: After reset, and at all times, `gain_code` lies in 0..6 (code k = 6k-6 dB). Reset sets it to 6 (+30 dB).
- R2: When a window of 256 accepted samples ends with a peak magnitude above 112, the code drops by one, stopping at 0.
- R3: When a window ends with a peak magnitude below 48, the code rises by one, stopping at 6.
- R4: When a window ends with a peak from 48 to 112 inclusive, the code is unchanged.
- R5: From the clock edge that first samples `tx_data_n` low, `gain_code` is 0, and it stays 0 while `tx_data_n` stays low.
- R6: On the clock edge that first samples `tx_data_n` high after a transmit, `gain_code` returns to the code in effect just before that transmit began.
- R7: While transmitting, the loop is frozen and samples are ignored. A window that was partly filled when the transmit started is discarded, so counting starts from a fresh window afterwards.
- R8: While `pwr_down` is high, `gain_code` is 6 from the next edge, and samples and the transmit line have no effect. The kept code is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwr_down | input | 1 | Power-down, active high |
| tx_data_n | input | 1 | Transmit data, active low (low = sending) |
| smp_valid | input | 1 | Sample strobe |
| smp_mag | input | 8 | Unsigned sample magnitude |
| gain_code | output | 3 | Amplifier gain code, 0..6 |

## Verification
The assertions take it that `tx_data_n`, `pwr_down` and the sample strobe are already synchronous to `clk`. They also assume a gain step decided at a window end is only ever applied on the following edge, and is dropped if a transmit or power-down arrives in between. The stimulus changes every input only at the falling clock edge. It fills each window completely before it samples the gain, and it starts a transmit only between windows, except in the one test that deliberately cuts a window short. Each value the bench expects comes from the code steps given in the requirements, never from the design's internal state.

// File: rtl/agc_pkg.sv
// Shared types and constants for the receive gain hold block.
// Assumes the gain code is a 3-bit value in 6 dB steps, 0..6.
package agc_pkg;
    localparam int CODE_W   = 3;
    localparam int CODE_MAX = 6;
    localparam int MAG_W    = 8;

    typedef logic [CODE_W-1:0] gain_t;

    // Decision produced at the end of each observation window.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2
    } step_e;
endpackage

// File: rtl/agc_peak_window.sv
// Peak detector over a fixed window of accepted samples.
// At the end of each window it emits a one-cycle step decision.
// Assumes that clear (freeze or power-down) discards a partly filled window.
module agc_peak_window
    import agc_pkg::*;
#(
    parameter int WIN_LEN = 256,
    parameter int HI_TH   = 112,
    parameter int LO_TH   = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             smp_valid,
    input  logic [MAG_W-1:0] smp_mag,
    output step_e            step
);
    localparam int CNT_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_LEN - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [MAG_W-1:0] peak_q;
    logic [MAG_W-1:0] peak_next;
    step_e            step_q;

    // Running maximum including the current sample.
    always_comb begin
        peak_next = (smp_mag > peak_q) ? smp_mag : peak_q;
    end

    // Count samples, track the peak and decide at the window end.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q  <= '0;
            peak_q <= '0;
            step_q <= STEP_HOLD;
        end else begin
            step_q <= STEP_HOLD;
            if (smp_valid) begin
                if (cnt_q == LAST) begin
                    cnt_q  <= '0;
                    peak_q <= '0;
                    if (peak_next > MAG_W'(HI_TH))
                        step_q <= STEP_DN;
                    else if (peak_next < MAG_W'(LO_TH))
                        step_q <= STEP_UP;
                end else begin
                    cnt_q  <= cnt_q + 1'b1;
                    peak_q <= peak_next;
                end
            end
        end
    end

    assign step = step_q;

    AST_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> step == STEP_HOLD); // R7
endmodule

// File: rtl/agc_code_stepper.sv
// Saturating up/down gain code register driven by window decisions.
// Assumes that freeze blocks all updates and power-down forces maximum gain.
module agc_code_stepper
    import agc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pwr_down,
    input  logic  freeze,
    input  step_e step,
    output gain_t track_code
);
    localparam gain_t MAXC = gain_t'(CODE_MAX);

    gain_t track_q;

    // Apply one step per decision and saturate at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down) begin
            track_q <= MAXC;
        end else if (!freeze) begin
            if (step == STEP_DN && track_q != '0)
                track_q <= track_q - 1'b1;
            else if (step == STEP_UP && track_q != MAXC)
                track_q <= track_q + 1'b1;
        end
    end

    assign track_code = track_q;

    AST_FROZEN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !pwr_down) |=> track_q == $past(track_q)); // R7
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_DN && !freeze && !pwr_down && track_q != '0)
        |=> track_q == $past(track_q) - 1'b1); // R2
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_UP && !freeze && !pwr_down && track_q != MAXC)
        |=> track_q == $past(track_q) + 1'b1); // R3
endmodule

// File: rtl/agc_hold_ctrl.sv
// Save, force and restore control for the output gain code.
// On transmit start it keeps the tracked code and drives code 0;
// on transmit end it drives the kept code again.
// Assumes tx_act is synchronous to clk.
module agc_hold_ctrl
    import agc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pwr_down,
    input  logic  tx_act,
    input  gain_t track_code,
    output logic  forced,
    output gain_t gain_code
);
    localparam gain_t MAXC = gain_t'(CODE_MAX);

    gain_t gain_q;
    gain_t saved_q;
    logic  forced_q;

    // Sequence the output between tracking, forced-low and restore.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down) begin
            gain_q   <= MAXC;
            saved_q  <= '0;
            forced_q <= 1'b0;
        end else if (tx_act) begin
            if (!forced_q)
                saved_q <= track_code;
            forced_q <= 1'b1;
            gain_q   <= '0;
        end else if (forced_q) begin
            forced_q <= 1'b0;
            gain_q   <= saved_q;
        end else begin
            gain_q   <= track_code;
        end
    end

    assign forced    = forced_q;
    assign gain_code = gain_q;

    AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_act && !pwr_down) |=> gain_q == '0); // R5
    AST_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (forced_q && !tx_act && !pwr_down) |=> gain_q == $past(saved_q)); // R6
    AST_PD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> gain_q == MAXC); // R8
    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        gain_q <= MAXC); // R1
endmodule

// File: rtl/agc_gain_hold.sv
// Top of the receive gain hold block: peak window, code stepper and
// transmit hold control. Assumes all inputs are synchronous to clk.
module agc_gain_hold
    import agc_pkg::*;
#(
    parameter int WIN_LEN = 256,
    parameter int HI_TH   = 112,
    parameter int LO_TH   = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_down,
    input  logic                tx_data_n,
    input  logic                smp_valid,
    input  logic [MAG_W-1:0]    smp_mag,
    output logic [CODE_W-1:0]   gain_code
);
    logic  tx_act;
    logic  forced;
    logic  freeze;
    step_e step;
    gain_t track_code;

    // Transmit is active low; freeze covers the restore cycle as well.
    assign tx_act = ~tx_data_n;
    assign freeze = tx_act | forced;

    agc_peak_window #(
        .WIN_LEN (WIN_LEN),
        .HI_TH   (HI_TH),
        .LO_TH   (LO_TH)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (freeze | pwr_down),
        .smp_valid (smp_valid),
        .smp_mag   (smp_mag),
        .step      (step)
    );

    agc_code_stepper u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_down   (pwr_down),
        .freeze     (freeze),
        .step       (step),
        .track_code (track_code)
    );

    agc_hold_ctrl u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_down   (pwr_down),
        .tx_act     (tx_act),
        .track_code (track_code),
        .forced     (forced),
        .gain_code  (gain_code)
    );
endmodule

// File: tb/sim_agc_gain_hold.sv
module sim_agc_gain_hold;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_down = 1'b0;
    logic       tx_data_n = 1'b1;
    logic       smp_valid = 1'b0;
    logic [7:0] smp_mag = 8'd0;
    logic [2:0] gain_code;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk; // 125 MHz

    agc_gain_hold u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_down  (pwr_down),
        .tx_data_n (tx_data_n),
        .smp_valid (smp_valid),
        .smp_mag   (smp_mag),
        .gain_code (gain_code)
    );

    // {peak magnitude of window, expected code after it}, starting from 6.
    localparam int NV = 16;
    localparam logic [10:0] VEC [NV] = '{
        {8'd200, 3'd5}, {8'd113, 3'd4}, {8'd112, 3'd4}, {8'd48,  3'd4},
        {8'd47,  3'd5}, {8'd0,   3'd6}, {8'd10,  3'd6}, {8'd255, 3'd5},
        {8'd255, 3'd4}, {8'd255, 3'd3}, {8'd255, 3'd2}, {8'd255, 3'd1},
        {8'd255, 3'd0}, {8'd255, 3'd0}, {8'd60,  3'd0}, {8'd20,  3'd1}
    };

    task automatic check(input string req, input logic [2:0] exp);
        n_chk++;
        if (gain_code !== exp) begin
            n_bad++;
            $display("FAIL %s: gain_code=%0d expected=%0d", req, gain_code, exp);
        end
    endtask

    task automatic feed(input int n, input logic [7:0] mag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_valid = 1'b1;
            smp_mag   = mag;
        end
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset to max", 3'd6);

        // Table walk: R2 down, R3 up, R4 hold, saturation at both ends.
        for (int v = 0; v < NV; v++) begin
            feed(256, VEC[v][10:3]);
            check($sformatf("R2/R3/R4 vector %0d mag %0d", v, VEC[v][10:3]), VEC[v][2:0]);
        end

        // Bring code to 3.
        feed(256, 8'd20);
        feed(256, 8'd20);
        check("R3 step up to 3", 3'd3);

        // R5: forced low from the first edge that sees tx low.
        @(negedge clk);
        tx_data_n = 1'b0;
        @(negedge clk);
        check("R5 forced low on first edge", 3'd0);
        // R7: quiet samples during transmit must not raise the code.
        feed(256, 8'd5);
        feed(256, 8'd5);
        check("R5 still low during tx", 3'd0);
        // R6: restore on the first edge that sees tx high.
        tx_data_n = 1'b1;
        @(negedge clk);
        check("R6 restored code", 3'd3);
        feed(256, 8'd80);
        check("R7 loop not moved by tx", 3'd3);

        // R7: partial window before tx must be discarded.
        feed(100, 8'd255);
        tx_data_n = 1'b0;
        repeat (4) @(negedge clk);
        tx_data_n = 1'b1;
        repeat (2) @(negedge clk);
        feed(156, 8'd80);
        check("R7 partial window discarded (mid)", 3'd3);
        feed(100, 8'd80);
        check("R7 fresh window of hold level", 3'd3);

        // R8: power-down forces max and ignores samples and tx.
        pwr_down = 1'b1;
        @(negedge clk);
        check("R8 power-down max", 3'd6);
        tx_data_n = 1'b0;
        feed(256, 8'd255);
        check("R8 samples and tx ignored", 3'd6);
        tx_data_n = 1'b1;
        @(negedge clk);
        pwr_down = 1'b0;
        @(negedge clk);
        check("R8 max after power-down", 3'd6);
        // Transmit after power-down restores the code then in effect.
        tx_data_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 forced after power-down", 3'd0);
        tx_data_n = 1'b1;
        @(negedge clk);
        check("R6 restore after power-down", 3'd6);

        // Reset in the middle of a transmit.
        tx_data_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        tx_data_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset clears forcing", 3'd6);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule